// File: doc/BRIEF.md
# Bus Security Rule Checker

This gate sits between an AHB-style interconnect and a single memory slave. In each address phase it reads three attributes of the transfer: the security state (taken from the incoming non-secure flag), the privilege level, and whether the transfer is an instruction fetch or a data access. It finds the rule for the addressed region in a packed rule table and decides whether the transfer may reach the slave.

Instruction fetches need an exact match between the requester's level and the region's level. Data accesses follow a hierarchy. Non-secure requesters never reach secure regions. When privilege checking is enabled for the transaction's security state, unprivileged requesters are kept out of privileged regions.

A refused transfer never reaches the slave. The master receives a two-cycle error response instead. The first refused transfer is recorded in a sticky capture register, which software clears with a write-one pulse.

Top module: `bus_rule_gate`

## Requirements
- R1: While `en_secure_check` is 0, every selected transfer is forwarded on `slv_sel` and no error response is generated.
- R2: Region n owns bits [4n+3:4n] of `rule_table`. Only the low two bits of a field are used, encoded 0 = non-secure unprivileged, 1 = non-secure privileged, 2 = secure unprivileged, 3 = secure privileged. Bit 1 of the field is the security bit and bit 0 is the privilege bit. The region index is `haddr[17:15]` (default `REGION_LSB` = 15). Address bits above the index are ignored.
- R3: An instruction fetch (`hinstr`=1) is forwarded only when the requester's level {~hnonsec, hpriv} equals the region's 2-bit rule exactly. The privilege-check enables have no effect on fetches.
- R4: A non-secure data access to a region whose rule has bit 1 set is always refused. A secure data access to a non-secure region is allowed.
- R5: With privilege checking enabled for the transaction's state, an unprivileged data access to a region with rule bit 0 set is refused. A privileged data access is allowed to both privileged and unprivileged regions of a reachable security state.
- R6: `en_priv_chk_s` governs secure transactions and `en_priv_chk_ns` governs non-secure transactions. While the governing enable is 0, an unprivileged data access to a privileged region is allowed.
- R7: Writes are judged by the same data rules as reads.
- R8: A refused transfer keeps `slv_sel` low in its address phase. In the next cycle the gate drives `hresp_out`=1 with `hready_out`=0, and in the cycle after that `hresp_out`=1 with `hready_out`=1.
- R9: Outside the error response, `hready_out` and `hresp_out` follow `slv_hready` and `slv_hresp`.
- R10: The first refused transfer sets `viol_valid` and stores its address and attributes, one clock after its address phase. Later refusals leave the stored values unchanged while `viol_valid` is set.
- R11: A `viol_clr` pulse clears `viol_valid` on the next clock. A refusal in the same cycle as the pulse is captured as a new first violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_secure_check | input | 1 | Global rule enforcement enable |
| en_priv_chk_s | input | 1 | Privilege check enable for secure transactions |
| en_priv_chk_ns | input | 1 | Privilege check enable for non-secure transactions |
| rule_table | input | 32*ceil(NUM_REGIONS/8) | Packed 4-bit rule fields, region 0 lowest |
| viol_clr | input | 1 | Write-one-to-clear pulse for the capture flag |
| hsel | input | 1 | Slave select from the decoder |
| htrans | input | 2 | Transfer type; bit 1 high marks an active transfer |
| haddr | input | ADDR_W | Transfer address |
| hwrite | input | 1 | Write transfer |
| hnonsec | input | 1 | Transfer is non-secure |
| hpriv | input | 1 | Transfer is privileged |
| hinstr | input | 1 | Transfer is an instruction fetch |
| slv_hready | input | 1 | Ready from the memory slave |
| slv_hresp | input | 1 | Error response from the memory slave |
| slv_sel | output | 1 | Select forwarded to the memory slave |
| hready_out | output | 1 | Ready returned to the master |
| hresp_out | output | 1 | Error response returned to the master |
| viol_valid | output | 1 | Sticky violation flag |
| viol_addr | output | ADDR_W | Address of the captured violation |
| viol_nonsec | output | 1 | Captured non-secure flag |
| viol_priv | output | 1 | Captured privilege flag |
| viol_instr | output | 1 | Captured fetch flag |
| viol_write | output | 1 | Captured write flag |

## Verification
The corner cases hardest to reach from the ports are where a refusal collides with other activity. One is a refusal in the same cycle as a clear pulse, which must replace the capture and not be lost. Another is a run of refusals that must leave the first capture untouched. A third is a rule field whose unused upper bits are set, which must not change the decision. The directed part of the stimulus uses a rule word with one region of each level and a region with junk upper bits, walks every requester level across them with fetches, reads and writes, and issues one refusal together with a clear. Seeded random transfers with random rule words, random enables and periodic clears then cover the remaining combinations.

// File: rtl/bus_rule_pkg.sv
package bus_rule_pkg;

    localparam int RULE_FIELD_W    = 4;
    localparam int RULE_WORD_W     = 32;
    localparam int FIELDS_PER_WORD = RULE_WORD_W / RULE_FIELD_W;

    // bit 1: secure, bit 0: privileged
    typedef enum logic [1:0] {
        LVL_NS_USER = 2'd0,
        LVL_NS_PRIV = 2'd1,
        LVL_S_USER  = 2'd2,
        LVL_S_PRIV  = 2'd3
    } sec_level_e;

    typedef struct packed {
        logic nonsec;
        logic priv;
        logic instr;
        logic write;
    } xfer_attr_t;

    typedef struct packed {
        logic allow;
        logic strict_fail;
        logic sec_fail;
        logic priv_fail;
    } verdict_t;

    typedef enum logic [1:0] {
        RSP_PASS     = 2'd0,
        RSP_ERR_WAIT = 2'd1,
        RSP_ERR_DONE = 2'd2
    } rsp_state_e;

    function automatic sec_level_e requester_level(input xfer_attr_t a);
        return sec_level_e'({~a.nonsec, a.priv});
    endfunction

    function automatic logic level_is_secure(input sec_level_e l);
        return l[1];
    endfunction

    function automatic logic level_is_priv(input sec_level_e l);
        return l[0];
    endfunction

endpackage

// File: rtl/rule_lookup.sv
module rule_lookup
    import bus_rule_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int REGION_LSB  = 15,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int NUM_WORDS  = (NUM_REGIONS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD,
    localparam int TABLE_W    = NUM_WORDS * RULE_WORD_W
) (
    input  logic [TABLE_W-1:0] rule_table,
    input  logic [ADDR_W-1:0]  addr,
    output sec_level_e         level
);

    logic [1:0]       lvl_arr [NUM_REGIONS];
    logic [IDX_W-1:0] idx;

    genvar g;
    generate
        for (g = 0; g < NUM_REGIONS; g++) begin : g_field
            assign lvl_arr[g] = rule_table[g*RULE_FIELD_W +: 2];
        end
    endgenerate

    assign idx   = addr[REGION_LSB +: IDX_W];
    assign level = sec_level_e'(lvl_arr[idx]);

endmodule

// File: rtl/access_judge.sv
module access_judge
    import bus_rule_pkg::*;
(
    input  xfer_attr_t attr,
    input  sec_level_e rule,
    input  logic       en_check,
    input  logic       en_priv_s,
    input  logic       en_priv_ns,
    output verdict_t   verdict
);

    logic       priv_chk_on;
    sec_level_e req_lvl;

    always_comb begin
        req_lvl     = requester_level(attr);
        priv_chk_on = attr.nonsec ? en_priv_ns : en_priv_s;

        verdict.strict_fail = attr.instr && (req_lvl != rule);
        verdict.sec_fail    = !attr.instr && attr.nonsec && level_is_secure(rule);
        verdict.priv_fail   = !attr.instr && priv_chk_on && level_is_priv(rule) && !attr.priv;
        verdict.allow       = !en_check ||
                              !(verdict.strict_fail || verdict.sec_fail || verdict.priv_fail);
    end

endmodule

// File: rtl/err_responder.sv
module err_responder
    import bus_rule_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic block_evt,
    input  logic slv_hready,
    input  logic slv_hresp,
    output logic hready_out,
    output logic hresp_out
);

    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_PASS:     if (block_evt) state_d = RSP_ERR_WAIT;
            RSP_ERR_WAIT: state_d = RSP_ERR_DONE;
            RSP_ERR_DONE: state_d = block_evt ? RSP_ERR_WAIT : RSP_PASS;
            default:      state_d = RSP_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RSP_PASS;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RSP_ERR_WAIT: begin hready_out = 1'b0;       hresp_out = 1'b1;      end
            RSP_ERR_DONE: begin hready_out = 1'b1;       hresp_out = 1'b1;      end
            default:      begin hready_out = slv_hready; hresp_out = slv_hresp; end
        endcase
    end

endmodule

// File: rtl/viol_capture.sv
module viol_capture
    import bus_rule_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_evt,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  xfer_attr_t        attr,
    output logic              valid_q,
    output logic [ADDR_W-1:0] addr_q,
    output xfer_attr_t        attr_q
);

    logic take;

    assign take = capture_evt && (!valid_q || clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            attr_q  <= '0;
        end else begin
            if (clr) valid_q <= 1'b0;
            if (take) begin
                valid_q <= 1'b1;
                addr_q  <= addr;
                attr_q  <= attr;
            end
        end
    end

endmodule

// File: rtl/bus_rule_gate.sv
module bus_rule_gate
    import bus_rule_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int REGION_LSB  = 15,
    localparam int NUM_WORDS  = (NUM_REGIONS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD,
    localparam int TABLE_W    = NUM_WORDS * RULE_WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_secure_check,
    input  logic               en_priv_chk_s,
    input  logic               en_priv_chk_ns,
    input  logic [TABLE_W-1:0] rule_table,
    input  logic               viol_clr,
    input  logic               hsel,
    input  logic [1:0]         htrans,
    input  logic [ADDR_W-1:0]  haddr,
    input  logic               hwrite,
    input  logic               hnonsec,
    input  logic               hpriv,
    input  logic               hinstr,
    input  logic               slv_hready,
    input  logic               slv_hresp,
    output logic               slv_sel,
    output logic               hready_out,
    output logic               hresp_out,
    output logic               viol_valid,
    output logic [ADDR_W-1:0]  viol_addr,
    output logic               viol_nonsec,
    output logic               viol_priv,
    output logic               viol_instr,
    output logic               viol_write
);

    xfer_attr_t attr;
    sec_level_e rule_lvl;
    verdict_t   verdict;
    xfer_attr_t cap_attr;
    logic       xfer_go;
    logic       block_evt;

    assign attr.nonsec = hnonsec;
    assign attr.priv   = hpriv;
    assign attr.instr  = hinstr;
    assign attr.write  = hwrite;

    rule_lookup #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .REGION_LSB  (REGION_LSB)
    ) u_lookup (
        .rule_table (rule_table),
        .addr       (haddr),
        .level      (rule_lvl)
    );

    access_judge u_judge (
        .attr       (attr),
        .rule       (rule_lvl),
        .en_check   (en_secure_check),
        .en_priv_s  (en_priv_chk_s),
        .en_priv_ns (en_priv_chk_ns),
        .verdict    (verdict)
    );

    assign xfer_go   = hsel && htrans[1] && hready_out;
    assign block_evt = xfer_go && !verdict.allow;
    assign slv_sel   = hsel && !block_evt;

    err_responder u_rsp (
        .clk        (clk),
        .rst        (rst),
        .block_evt  (block_evt),
        .slv_hready (slv_hready),
        .slv_hresp  (slv_hresp),
        .hready_out (hready_out),
        .hresp_out  (hresp_out)
    );

    viol_capture #(
        .ADDR_W (ADDR_W)
    ) u_cap (
        .clk         (clk),
        .rst         (rst),
        .capture_evt (block_evt),
        .clr         (viol_clr),
        .addr        (haddr),
        .attr        (attr),
        .valid_q     (viol_valid),
        .addr_q      (viol_addr),
        .attr_q      (cap_attr)
    );

    assign viol_nonsec = cap_attr.nonsec;
    assign viol_priv   = cap_attr.priv;
    assign viol_instr  = cap_attr.instr;
    assign viol_write  = cap_attr.write;

endmodule

// File: rtl/bus_rule_gate_chk.sv
module bus_rule_gate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              en_secure_check,
    input logic              viol_clr,
    input logic              hsel,
    input logic              hnonsec,
    input logic              hpriv,
    input logic              hinstr,
    input logic [1:0]        rule_lvl,
    input logic              xfer_go,
    input logic              slv_sel,
    input logic              hready_out,
    input logic              hresp_out,
    input logic              viol_valid,
    input logic [ADDR_W-1:0] viol_addr
);

    p_off_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (!en_secure_check && hsel) |-> slv_sel);

    p_fetch_strict_r3: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && en_secure_check && hinstr && (rule_lvl != {~hnonsec, hpriv})) |-> !slv_sel);

    p_ns_to_s_r4: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && en_secure_check && hnonsec && !hinstr && rule_lvl[1]) |-> !slv_sel);

    p_err_first_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && !slv_sel) |=> (hresp_out && !hready_out));

    p_err_second_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && !slv_sel) |-> ##2 (hresp_out && hready_out));

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && !viol_clr) |=> (viol_valid && $stable(viol_addr)));

    p_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && !slv_sel) |=> viol_valid);

    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (viol_clr && !(xfer_go && !slv_sel)) |=> !viol_valid);

endmodule

bind bus_rule_gate bus_rule_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .en_secure_check (en_secure_check),
    .viol_clr        (viol_clr),
    .hsel            (hsel),
    .hnonsec         (hnonsec),
    .hpriv           (hpriv),
    .hinstr          (hinstr),
    .rule_lvl        (rule_lvl),
    .xfer_go         (xfer_go),
    .slv_sel         (slv_sel),
    .hready_out      (hready_out),
    .hresp_out       (hresp_out),
    .viol_valid      (viol_valid),
    .viol_addr       (viol_addr)
);

// File: tb/bus_rule_gate_bench.sv
module bus_rule_gate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_secure_check = 1'b0;
    logic        en_priv_chk_s = 1'b0;
    logic        en_priv_chk_ns = 1'b0;
    logic [31:0] rule_table = '0;
    logic        viol_clr = 1'b0;
    logic        hsel = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic [31:0] haddr = '0;
    logic        hwrite = 1'b0;
    logic        hnonsec = 1'b0;
    logic        hpriv = 1'b0;
    logic        hinstr = 1'b0;
    logic        slv_hready = 1'b1;
    logic        slv_hresp = 1'b0;
    logic        slv_sel, hready_out, hresp_out;
    logic        viol_valid, viol_nonsec, viol_priv, viol_instr, viol_write;
    logic [31:0] viol_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit          m_valid = 0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_attr = '0;

    always #2 clk = ~clk;

    bus_rule_gate u_bus_rule_gate (
        .clk (clk), .rst (rst),
        .en_secure_check (en_secure_check), .en_priv_chk_s (en_priv_chk_s),
        .en_priv_chk_ns (en_priv_chk_ns), .rule_table (rule_table),
        .viol_clr (viol_clr), .hsel (hsel), .htrans (htrans), .haddr (haddr),
        .hwrite (hwrite), .hnonsec (hnonsec), .hpriv (hpriv), .hinstr (hinstr),
        .slv_hready (slv_hready), .slv_hresp (slv_hresp), .slv_sel (slv_sel),
        .hready_out (hready_out), .hresp_out (hresp_out), .viol_valid (viol_valid),
        .viol_addr (viol_addr), .viol_nonsec (viol_nonsec), .viol_priv (viol_priv),
        .viol_instr (viol_instr), .viol_write (viol_write)
    );

    function automatic bit exp_allow(input logic [31:0] cfg, input logic [31:0] a,
                                     input bit ns, input bit pv, input bit ins);
        int   idx;
        logic [1:0] lvl;
        bit   pc;
        idx = int'(a[17:15]);
        lvl = cfg[idx*4 +: 2];
        if (!en_secure_check) return 1'b1;
        if (ins) return (lvl == {~ns, pv});
        if (ns && lvl[1]) return 1'b0;
        pc = ns ? en_priv_chk_ns : en_priv_chk_s;
        if (pc && lvl[0] && !pv) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_xfer(input logic [31:0] a, input bit ns, input bit pv, input bit ins,
                           input bit wr, input bit clr, input string tag);
        bit ok;
        ok = exp_allow(rule_table, a, ns, pv, ins);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = a;
        hnonsec = ns; hpriv = pv; hinstr = ins; hwrite = wr; viol_clr = clr;
        #1;
        chk(slv_sel === ok, tag, 64'(slv_sel), 64'(ok));
        if (clr) m_valid = 0;
        if (!ok && !m_valid) begin
            m_valid = 1; m_addr = a; m_attr = {ns, pv, ins, wr};
        end
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; viol_clr = 1'b0;
        #1;
        if (!ok) begin
            chk(hresp_out === 1'b1 && hready_out === 1'b0, "R8 err cycle1",
                64'({hresp_out, hready_out}), 64'h2);
            chk(viol_valid === m_valid && viol_addr === m_addr &&
                {viol_nonsec, viol_priv, viol_instr, viol_write} === m_attr,
                "R10 capture", {viol_valid, viol_addr, viol_nonsec, viol_priv, viol_instr, viol_write},
                {m_valid, m_addr, m_attr});
            @(negedge clk);
            #1;
            chk(hresp_out === 1'b1 && hready_out === 1'b1, "R8 err cycle2",
                64'({hresp_out, hready_out}), 64'h3);
        end else begin
            chk(hresp_out === 1'b0 && hready_out === 1'b1, "R9 passthrough",
                64'({hresp_out, hready_out}), 64'h1);
            chk(viol_valid === m_valid, "R10 flag", 64'(viol_valid), 64'(m_valid));
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
        #1;
        m_valid = 0;
        chk(viol_valid === 1'b0, "R11 clear", 64'(viol_valid), 64'h0);
    endtask

    localparam logic [31:0] RG0 = 32'h0000_0000;
    localparam logic [31:0] RG1 = 32'h0000_8000;
    localparam logic [31:0] RG2 = 32'h0001_0000;
    localparam logic [31:0] RG3 = 32'h0001_8000;
    localparam logic [31:0] RG4 = 32'h0002_0000;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(hready_out === 1'b1 && hresp_out === 1'b0 && viol_valid === 1'b0, "reset state",
            64'({hready_out, hresp_out, viol_valid}), 64'h4);

        // R2: regions 0..4 = S-P, S-U, NS-P, NS-U, 0xB (low bits 3)
        rule_table = 32'h000B_0123;

        // R1: enforcement off
        en_secure_check = 1'b0; en_priv_chk_s = 1'b1; en_priv_chk_ns = 1'b1;
        do_xfer(RG0 + 32'h10, 1, 0, 0, 1, 0, "R1 off ns-user write to S-P");
        do_xfer(RG0, 1, 0, 1, 0, 0, "R1 off fetch mismatch");

        en_secure_check = 1'b1;
        // R2: upper field bits ignored, address alias
        do_xfer(RG4 + 32'h4, 1, 0, 0, 0, 0, "R2 field 0xB is secure");
        do_xfer(RG4, 0, 1, 1, 0, 0, "R2 field 0xB fetch S-P");
        do_xfer(32'hFFF0_0000 | RG1, 0, 0, 1, 0, 0, "R2 alias high bits");

        // R3: strict fetch
        do_xfer(RG0, 0, 1, 1, 0, 0, "R3 S-P fetch S-P");
        do_xfer(RG0, 0, 0, 1, 0, 0, "R3 S-U fetch S-P");
        do_xfer(RG1, 0, 1, 1, 0, 0, "R3 S-P fetch S-U");
        do_xfer(RG3, 1, 0, 1, 0, 0, "R3 NS-U fetch NS-U");
        do_xfer(RG3, 0, 1, 1, 0, 0, "R3 S-P fetch NS-U");

        // R4: non-secure to secure
        do_xfer(RG1, 1, 1, 0, 0, 0, "R4 NS-P read S-U");
        do_xfer(RG3, 0, 0, 0, 0, 0, "R4 S-U read NS-U");

        // R5: privilege hierarchy with checks on
        do_xfer(RG0, 0, 0, 0, 0, 0, "R5 S-U read S-P");
        do_xfer(RG1, 0, 1, 0, 0, 0, "R5 S-P read S-U");
        do_xfer(RG2, 0, 0, 0, 0, 0, "R5 S-U read NS-P");

        // R7: writes
        do_xfer(RG0, 0, 0, 0, 1, 0, "R7 S-U write S-P");
        do_xfer(RG2, 1, 0, 0, 1, 0, "R7 NS-U write NS-P");
        do_xfer(RG0, 0, 1, 0, 1, 0, "R7 S-P write S-P");

        do_clear();

        // R6: separate enables
        en_priv_chk_s = 1'b0; en_priv_chk_ns = 1'b1;
        do_xfer(RG0, 0, 0, 0, 1, 0, "R6 s-off S-U write S-P");
        do_xfer(RG2, 1, 0, 0, 0, 0, "R6 ns-on NS-U read NS-P");
        en_priv_chk_s = 1'b1; en_priv_chk_ns = 1'b0;
        do_xfer(RG2, 1, 0, 0, 0, 0, "R6 ns-off NS-U read NS-P");
        do_xfer(RG0, 0, 0, 0, 0, 0, "R6 s-on S-U read S-P");

        // R11: refusal in the same cycle as the clear pulse
        do_xfer(RG1, 1, 0, 0, 1, 1, "R11 clear with new refusal");

        // R9: slave response passes through while idle
        @(negedge clk);
        slv_hready = 1'b0; slv_hresp = 1'b1;
        #1;
        chk(hready_out === 1'b0 && hresp_out === 1'b1, "R9 slave response",
            64'({hready_out, hresp_out}), 64'h1);
        @(negedge clk);
        slv_hready = 1'b1; slv_hresp = 1'b0;

        // random phase
        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0) begin
                rule_table = $urandom();
                en_secure_check = ($urandom_range(9) != 0);
                en_priv_chk_s = $urandom_range(1);
                en_priv_chk_ns = $urandom_range(1);
            end
            if (i % 60 == 59) do_clear();
            do_xfer($urandom(), $urandom_range(1), $urandom_range(1), $urandom_range(1),
                    $urandom_range(1), 0, "R5 random mix");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule